// File: doc/BRIEF.md
# Asynchronous SRAM bus bridge

This block lets a synchronous on-chip host reach an external asynchronous static RAM whose data bus is fixed at 16 bits. The host issues one request at a time: a byte address, a size code, a direction flag and up to 32 bits of write data, qualified by a valid/ready handshake. The bridge turns each request into one or two timed memory accesses. It drives active-low chip select, read strobe, write strobe and a pair of byte-lane enables, together with a 21-bit halfword address. The bidirectional data bus appears as separate output, input and drive-enable signals. When the last access has finished, the bridge raises a one-cycle done pulse, with read data and an error flag.

Each access has three phases. Address setup holds chip select low with both strobes high. The data phase then holds the read or write strobe low. A turnaround follows, with every strobe released and the address still held. The length of each phase comes from a configuration input in clock cycles, and the lengths are captured when the request is accepted. Two configuration bits gate the traffic: one enables the memory bank, the other permits writes. A request these bits forbid never reaches the pins.

Top module: `sram_bridge`

## Requirements
- R1: After reset, req_ready is 1, rsp_done is 0, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_bl_n is 2'b11 and mem_dq_oe is 0.
- R2: A request with req_size 0 (8 bit) or 1 (16 bit) makes exactly one memory access, at mem_addr = req_addr[21:1]. A 16-bit read returns the word in rsp_rdata[15:0], with the upper bits zero.
- R3: A request with req_size 2 (32 bit) makes two accesses. The first is at req_addr[21:1] and carries bits 15:0. The second is at that address plus one, wrapping in 21 bits, and carries bits 31:16.
- R4: On a write, mem_bl_n is 2'b10 for an 8-bit write with req_addr[0]=0, which writes the low byte dq[7:0] from req_wdata[7:0]. It is 2'b01 for an 8-bit write with req_addr[0]=1, which writes dq[15:8] from req_wdata[7:0]. It is 2'b00 for 16- and 32-bit writes.
- R5: While mem_oe_n is low, mem_bl_n is 2'b00. An 8-bit read returns the byte that req_addr[0] selects (0 selects low, 1 selects high) in rsp_rdata[7:0], with the upper bits zero.
- R6: Each access holds mem_ce_n low with both strobes high for the setup length S. It then holds one strobe low for the data length D. A turnaround of T cycles with mem_ce_n high follows each access. rsp_done rises n*(S+D+T)+1 cycles after the accepting edge, where n is the number of accesses. Defaults are S=3, D=6 and T=1.
- R7: A configured phase length of 0 behaves as a length of 1.
- R8: mem_dq_oe is 1 exactly during cycles where mem_we_n is low, and is never 1 while mem_oe_n is low or mem_ce_n is high.
- R9: A write while cfg_wr_en=0, or any request while cfg_bank_en=0, produces no memory access. It also produces rsp_done and rsp_err high in the first cycle after acceptance. Permitted requests end with rsp_err=0.
- R10: req_ready is low from the cycle after acceptance through the done cycle. rsp_done is a single-cycle pulse.
- R11: Read data is captured from mem_dq_in on the last cycle of the data phase, and the bus value in earlier data cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bank_en | input | 1 | Memory bank enable |
| cfg_wr_en | input | 1 | Write permission |
| cfg_setup_len | input | 4 | Address setup length in cycles |
| cfg_data_len | input | 4 | Data phase length in cycles |
| cfg_turn_len | input | 4 | Turnaround length in cycles |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 2 | 0 = 8 bit, 1 = 16 bit, 2 = 32 bit |
| req_addr | input | 22 | Host byte address |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request refused, valid with rsp_done |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_bl_n | output | 2 | Byte-lane enables, bit 0 low byte, active low |
| mem_addr | output | 21 | Memory halfword address |
| mem_dq_out | output | 16 | Data driven onto the memory bus |
| mem_dq_in | input | 16 | Data read from the memory bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
A phase counter that is off by one shows up at once in the number of strobe-low or setup cycles of the affected access, and it also moves the done pulse. A wrong half-select or address-increment state puts the upper halfword at the wrong address, or in the wrong order. Such an error surfaces as corrupted data on the next read of that location. A stale direction or lane state shows as wrong byte enables, or as bus drive during a read, in the very cycle the strobe falls. A wrong capture point returns the filler pattern the bench model drives before the last data cycle.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_DATA  = 3'd2,
        PH_TURN  = 3'd3,
        PH_DONE  = 3'd4
    } phase_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int N_PHASES = 3;

endpackage

// File: rtl/sram_len_clamp.sv
module sram_len_clamp #(
    parameter int W = 4
) (
    input  logic [W-1:0] len_i,
    output logic [W-1:0] len_m1_o
);
    // a length of zero counts as a single cycle
    always_comb begin
        if (len_i == '0) len_m1_o = '0;
        else             len_m1_o = len_i - 1'b1;
    end
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
    parameter int DW = 16
) (
    input  logic [1:0]      size_i,
    input  logic            byte_sel_i,
    input  logic            upper_i,
    input  logic [2*DW-1:0] wdata_i,
    input  logic [2*DW-1:0] rd_acc_i,
    input  logic [DW-1:0]   dq_in_i,
    output logic [1:0]      bl_n_o,
    output logic [DW-1:0]   dq_out_o,
    output logic [2*DW-1:0] rd_next_o
);
    localparam int BW = DW / 2;
    localparam int HDW = 2 * DW;

    logic [BW-1:0] rd_byte;

    always_comb begin
        if (size_i == sram_bridge_pkg::SZ_BYTE) begin
            bl_n_o   = byte_sel_i ? 2'b01 : 2'b10;
            dq_out_o = {wdata_i[BW-1:0], wdata_i[BW-1:0]};
        end else begin
            bl_n_o   = 2'b00;
            dq_out_o = (size_i[1] && upper_i) ? wdata_i[HDW-1:DW] : wdata_i[DW-1:0];
        end
    end

    assign rd_byte = byte_sel_i ? dq_in_i[DW-1:BW] : dq_in_i[BW-1:0];

    always_comb begin
        if (size_i[1]) begin
            rd_next_o = upper_i ? {dq_in_i, rd_acc_i[DW-1:0]}
                                : {rd_acc_i[HDW-1:DW], dq_in_i};
        end else if (size_i[0]) begin
            rd_next_o = {{DW{1'b0}}, dq_in_i};
        end else begin
            rd_next_o = {{(HDW-BW){1'b0}}, rd_byte};
        end
    end
endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DW     = 16,
    parameter int PH_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_bank_en,
    input  logic                cfg_wr_en,
    input  logic [PH_W-1:0]     cfg_setup_len,
    input  logic [PH_W-1:0]     cfg_data_len,
    input  logic [PH_W-1:0]     cfg_turn_len,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*DW-1:0]     req_wdata,
    output logic                rsp_done,
    output logic                rsp_err,
    output logic [2*DW-1:0]     rsp_rdata,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [1:0]          mem_bl_n,
    output logic [ADDR_W-2:0]   mem_addr,
    output logic [DW-1:0]       mem_dq_out,
    input  logic [DW-1:0]       mem_dq_in,
    output logic                mem_dq_oe
);
    localparam int MEM_AW = ADDR_W - 1;
    localparam int HDW    = 2 * DW;

    typedef struct packed {
        phase_e              ph;
        logic [PH_W-1:0]     cnt;
        logic                upper;
        logic                write;
        logic [1:0]          size;
        logic                byte_sel;
        logic [MEM_AW-1:0]   haddr;
        logic [HDW-1:0]      wdata;
        logic [HDW-1:0]      rdata;
        logic                err;
        logic [PH_W-1:0]     s_m1;
        logic [PH_W-1:0]     d_m1;
        logic [PH_W-1:0]     t_m1;
    } state_t;

    state_t st_d, st_q;

    logic [PH_W-1:0] len_raw [N_PHASES];
    logic [PH_W-1:0] len_m1  [N_PHASES];

    assign len_raw[0] = cfg_setup_len;
    assign len_raw[1] = cfg_data_len;
    assign len_raw[2] = cfg_turn_len;

    for (genvar g = 0; g < N_PHASES; g++) begin : g_len
        sram_len_clamp #(.W(PH_W)) clamp_i (
            .len_i    (len_raw[g]),
            .len_m1_o (len_m1[g])
        );
    end

    logic [1:0]     lane_bl_n;
    logic [DW-1:0]  lane_dq;
    logic [HDW-1:0] rd_next;

    sram_lane_map #(.DW(DW)) lane_i (
        .size_i     (st_q.size),
        .byte_sel_i (st_q.byte_sel),
        .upper_i    (st_q.upper),
        .wdata_i    (st_q.wdata),
        .rd_acc_i   (st_q.rdata),
        .dq_in_i    (mem_dq_in),
        .bl_n_o     (lane_bl_n),
        .dq_out_o   (lane_dq),
        .rd_next_o  (rd_next)
    );

    logic refuse;
    assign refuse = !cfg_bank_en || (req_write && !cfg_wr_en);

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.write    = req_write;
                    st_d.size     = req_size;
                    st_d.byte_sel = req_addr[0];
                    st_d.haddr    = req_addr[ADDR_W-1:1];
                    st_d.wdata    = req_wdata;
                    st_d.rdata    = '0;
                    st_d.upper    = 1'b0;
                    st_d.s_m1     = len_m1[0];
                    st_d.d_m1     = len_m1[1];
                    st_d.t_m1     = len_m1[2];
                    st_d.err      = refuse;
                    if (refuse) begin
                        st_d.ph = PH_DONE;
                    end else begin
                        st_d.ph  = PH_SETUP;
                        st_d.cnt = len_m1[0];
                    end
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_DATA;
                    st_d.cnt = st_q.d_m1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_DATA: begin
                if (st_q.cnt == '0) begin
                    if (!st_q.write) st_d.rdata = rd_next;
                    st_d.ph  = PH_TURN;
                    st_d.cnt = st_q.t_m1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_TURN: begin
                if (st_q.cnt == '0) begin
                    if (st_q.size[1] && !st_q.upper) begin
                        st_d.upper = 1'b1;
                        st_d.haddr = st_q.haddr + 1'b1;
                        st_d.ph    = PH_SETUP;
                        st_d.cnt   = st_q.s_m1;
                    end else begin
                        st_d.ph = PH_DONE;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_DONE: st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic in_access, in_data;
    assign in_access = (st_q.ph == PH_SETUP) || (st_q.ph == PH_DATA);
    assign in_data   = (st_q.ph == PH_DATA);

    assign req_ready  = (st_q.ph == PH_IDLE);
    assign rsp_done   = (st_q.ph == PH_DONE);
    assign rsp_err    = (st_q.ph == PH_DONE) && st_q.err;
    assign rsp_rdata  = st_q.rdata;
    assign mem_ce_n   = !in_access;
    assign mem_oe_n   = !(in_data && !st_q.write);
    assign mem_we_n   = !(in_data && st_q.write);
    assign mem_bl_n   = !in_access ? 2'b11 : (st_q.write ? lane_bl_n : 2'b00);
    assign mem_addr   = st_q.haddr;
    assign mem_dq_out = lane_dq;
    assign mem_dq_oe  = in_data && st_q.write;

endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_done,
    input logic        rsp_err,
    input logic        mem_ce_n,
    input logic        mem_oe_n,
    input logic        mem_we_n,
    input logic [1:0]  mem_bl_n,
    input logic [20:0] mem_addr,
    input logic        mem_dq_oe
);
    p_read_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_bl_n == 2'b00));

    p_drive_write_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n && !mem_ce_n));

    p_strobe_in_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_ce_n);

    p_strobes_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_refused_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (mem_ce_n && rsp_done));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_done_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);
endmodule

bind sram_bridge sram_bridge_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_bl_n  (mem_bl_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_bridge_tb_top.sv
`timescale 1ns/1ps
module sram_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bank_en = 1'b1;
    logic        cfg_wr_en = 1'b1;
    logic [3:0]  cfg_setup_len = 4'd3;
    logic [3:0]  cfg_data_len = 4'd6;
    logic [3:0]  cfg_turn_len = 4'd1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [21:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic        mem_ce_n;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic [1:0]  mem_bl_n;
    logic [20:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;
    logic        mem_dq_oe;

    always #10 clk = ~clk;

    sram_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_bank_en(cfg_bank_en), .cfg_wr_en(cfg_wr_en),
        .cfg_setup_len(cfg_setup_len), .cfg_data_len(cfg_data_len),
        .cfg_turn_len(cfg_turn_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_bl_n(mem_bl_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;

    // transaction bookkeeping shared driver -> monitor
    int  txn_seq = 0;
    int  cur_d = 1;

    // monitor results
    int          mon_seq = -1;
    int          acc_cnt;
    int          ix;
    int          gap_cnt;
    int          gap_seen;
    bit          prev_ce;
    bit          rd_bl_bad;
    bit          oe_bad;
    int          setup_c [2];
    int          data_c  [2];
    logic [20:0] addr_seen [2];
    logic [1:0]  bl_seen   [2];

    logic [15:0] pmem [64];
    logic [15:0] smem [64];

    function automatic logic [15:0] init_word(input int i);
        return 16'(i * 16'h1357) ^ 16'hA0C3;
    endfunction

    function automatic int clamp1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [21:0] a);
        logic [5:0] i0;
        logic [5:0] i1;
        i0 = a[6:1];
        i1 = i0 + 6'd1;
        if (sz == 2'd2)      return {smem[i1], smem[i0]};
        else if (sz == 2'd1) return {16'h0, smem[i0]};
        else                 return {24'h0, a[0] ? smem[i0][15:8] : smem[i0][7:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // memory model and pin monitor
    initial begin
        for (int i = 0; i < 64; i++) pmem[i] = init_word(i);
        mem_dq_in = 16'h5A5A;
        forever begin
            @(negedge clk);
            if (mon_seq != txn_seq) begin
                mon_seq = txn_seq;
                acc_cnt = 0; ix = 0; gap_cnt = 0; gap_seen = -1;
                rd_bl_bad = 0; oe_bad = 0; prev_ce = 1;
                for (int k = 0; k < 2; k++) begin
                    setup_c[k] = 0; data_c[k] = 0;
                    addr_seen[k] = '0; bl_seen[k] = 2'b11;
                end
            end
            mem_dq_in = 16'h5A5A;
            if (rst_n && !mem_ce_n) begin
                if (prev_ce) begin
                    if (acc_cnt == 1) gap_seen = gap_cnt;
                    acc_cnt++;
                    ix = (acc_cnt > 2) ? 1 : acc_cnt - 1;
                    addr_seen[ix] = mem_addr;
                end
                if (mem_oe_n && mem_we_n) setup_c[ix]++;
                else                      data_c[ix]++;
                if (mem_dq_oe != !mem_we_n) oe_bad = 1;
                if (!mem_we_n) begin
                    bl_seen[ix] = mem_bl_n;
                    if (!mem_bl_n[0]) pmem[mem_addr[5:0]][7:0]  = mem_dq_out[7:0];
                    if (!mem_bl_n[1]) pmem[mem_addr[5:0]][15:8] = mem_dq_out[15:8];
                end
                if (!mem_oe_n) begin
                    if (mem_bl_n != 2'b00) rd_bl_bad = 1;
                    if (data_c[ix] == cur_d) mem_dq_in = pmem[mem_addr[5:0]];
                end
                gap_cnt = 0;
            end else if (rst_n) begin
                if (mem_dq_oe || !mem_oe_n || !mem_we_n) oe_bad = 1;
                gap_cnt++;
            end
            prev_ce = mem_ce_n;
        end
    end

    task automatic do_txn(input bit w, input logic [1:0] sz, input logic [21:0] a,
                          input logic [31:0] wd, input int s, input int d, input int t,
                          input bit bank, input bit wren);
        bit          refused;
        int          n, sp, dp, tp, lat;
        bit          rdy_bad;
        string       tg;
        logic [20:0] h;
        logic [1:0]  exp_bl;
        logic [5:0]  i0;
        refused = !bank || (w && !wren);
        n  = refused ? 0 : ((sz == 2'd2) ? 2 : 1);
        sp = clamp1(s); dp = clamp1(d); tp = clamp1(t);
        tg = (s == 0 || d == 0 || t == 0) ? "R7" : "R6";
        h  = a[21:1];
        txn_seq++;
        cur_d = dp;
        @(negedge clk);
        cfg_bank_en = bank; cfg_wr_en = wren;
        cfg_setup_len = 4'(s); cfg_data_len = 4'(d); cfg_turn_len = 4'(t);
        req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R10 ready idle", {31'h0, req_ready}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; rdy_bad = 0;
        while (!rsp_done && lat < 2000) begin
            if (req_ready) rdy_bad = 1;
            @(negedge clk);
            lat++;
        end
        if (req_ready) rdy_bad = 1;
        chk(!rdy_bad, "R10 ready low while busy", {31'h0, rdy_bad}, 32'h0);
        chk(rsp_err == refused, "R9 error flag", {31'h0, rsp_err}, {31'h0, refused});
        chk(lat == (refused ? 1 : n * (sp + dp + tp) + 1),
            refused ? "R9 latency" : {tg, " done latency"}, lat,
            refused ? 1 : n * (sp + dp + tp) + 1);
        chk(acc_cnt == n, refused ? "R9 no access" : (n == 2 ? "R3 access count" : "R2 access count"),
            acc_cnt, n);
        chk(!oe_bad, "R8 data drive", {31'h0, oe_bad}, 32'h0);
        if (!refused) begin
            for (int k = 0; k < n; k++) begin
                chk(addr_seen[k] == 21'(h + 21'(k)), n == 2 ? "R3 address" : "R2 address",
                    {11'h0, addr_seen[k]}, {11'h0, 21'(h + 21'(k))});
                chk(setup_c[k] == sp && data_c[k] == dp, {tg, " phase lengths"},
                    setup_c[k] * 256 + data_c[k], sp * 256 + dp);
                if (w) begin
                    exp_bl = (sz == 2'd0) ? (a[0] ? 2'b01 : 2'b10) : 2'b00;
                    chk(bl_seen[k] == exp_bl, "R4 write lanes", {30'h0, bl_seen[k]}, {30'h0, exp_bl});
                end
            end
            if (n == 2) chk(gap_seen == tp, {tg, " turnaround"}, gap_seen, tp);
            if (!w) begin
                chk(!rd_bl_bad, "R5 read lanes", {31'h0, rd_bl_bad}, 32'h0);
                chk(rsp_rdata == exp_read(sz, a),
                    sz == 2'd0 ? "R5 byte read R11" : (sz == 2'd1 ? "R2 half read R11" : "R3 word read R11"),
                    rsp_rdata, exp_read(sz, a));
            end else begin
                i0 = a[6:1];
                if (sz == 2'd0) begin
                    if (a[0]) smem[i0][15:8] = wd[7:0];
                    else      smem[i0][7:0]  = wd[7:0];
                end else begin
                    smem[i0] = wd[15:0];
                    if (sz == 2'd2) smem[6'(i0 + 6'd1)] = wd[31:16];
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        for (int i = 0; i < 64; i++) smem[i] = init_word(i);
        unused_seed = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_done && mem_ce_n && mem_oe_n && mem_we_n &&
            mem_bl_n == 2'b11 && !mem_dq_oe, "R1 reset state",
            {25'h0, req_ready, rsp_done, mem_ce_n, mem_oe_n, mem_we_n, mem_bl_n},
            {25'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11});

        // directed corners at the default timing
        do_txn(1, 2'd1, 22'h000010, 32'h1234BEEF, 3, 6, 1, 1, 1);
        do_txn(0, 2'd1, 22'h000010, 32'h0, 3, 6, 1, 1, 1);
        do_txn(1, 2'd0, 22'h000020, 32'h000000AA, 3, 6, 1, 1, 1);
        do_txn(1, 2'd0, 22'h000021, 32'h00000055, 3, 6, 1, 1, 1);
        do_txn(0, 2'd1, 22'h000020, 32'h0, 3, 6, 1, 1, 1);
        do_txn(0, 2'd0, 22'h000020, 32'h0, 3, 6, 1, 1, 1);
        do_txn(0, 2'd0, 22'h000021, 32'h0, 3, 6, 1, 1, 1);
        do_txn(1, 2'd2, 22'h3FFFFE, 32'hCAFE1234, 3, 6, 1, 1, 1);
        do_txn(0, 2'd2, 22'h3FFFFE, 32'h0, 3, 6, 1, 1, 1);
        do_txn(1, 2'd2, 22'h000044, 32'h89AB4567, 0, 0, 0, 1, 1);
        do_txn(0, 2'd2, 22'h000044, 32'h0, 0, 0, 0, 1, 1);
        do_txn(1, 2'd1, 22'h000050, 32'h0000FFFF, 3, 6, 1, 1, 0);
        do_txn(0, 2'd1, 22'h000050, 32'h0, 3, 6, 1, 0, 1);
        do_txn(0, 2'd1, 22'h000050, 32'h0, 3, 6, 1, 1, 0);
        do_txn(0, 2'd2, 22'h000052, 32'h0, 2, 5, 4, 1, 1);

        // constrained random traffic
        for (int r = 0; r < 400; r++) begin
            do_txn(bit'($urandom % 2), 2'($urandom % 3), 22'($urandom), $urandom,
                   int'($urandom % 6), int'($urandom % 6), int'($urandom % 6),
                   ($urandom % 8) != 0, ($urandom % 6) != 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule